// File: doc/BRIEF.md
# Bus-Busy Ownership Controller

This block sits on the master side of a shared bus whose ownership is signalled on a single bidirectional, tri-statable bus-busy line. An external arbiter grants the bus; the block decides when that grant can actually be used. It looks at the grant, the transfer-start line and the bus-busy line, and only on processor clock edges that a bus clock-enable marks. It takes the bus only when all three show a free bus, then drives bus-busy asserted for the whole tenure. When it gives the bus back, it drives the line negated for a single fast clock before it lets go.

Toward the internal bus sequencer the block takes a level request and a cycle-complete pulse. It returns a one-clock start-cycle pulse each time a bus cycle may begin. While the grant stays asserted, several cycles may follow one another without a release. A static mode input turns the whole protocol off when the system uses the alternative acknowledge-style ownership scheme instead. In that mode the busy line is neither watched nor driven.

All signals are active-high at the ports. Pad polarity is handled outside the block.

Top module: `busy_owner_ctl`

## Requirements
- R1: While reset is active and on the first clock after it, busy_oe, busy_o and start_cyc_o are all 0.
- R2: The bus is taken only on a clock where bus_ce=1, grant_i=1, start_i=0 and busy_i=0 are all seen together. Bus inputs on clocks with bus_ce=0 have no effect.
- R3: The first start_cyc_o pulse of a tenure appears in the same clock in which busy_oe=1 and busy_o=1 first appear. Each start_cyc_o pulse lasts one clock.
- R4: While the bus is owned, busy_o stays 1 for as long as a started cycle has not been closed by done_i, whatever grant_i does. Release is decided only at a bus_ce clock that sees grant_i=0.
- R5: Release drives busy_oe=1 with busy_o=0 for exactly one processor clock, whether or not bus_ce is active. On the next clock busy_oe returns to 0.
- R6: After a release the block treats busy_i as an input again, and needs a fresh free-bus sample before it re-takes the bus.
- R7: If grant_i=1 and req_i=1 at a bus_ce clock where the current cycle has completed (done_i in that same clock counts), a new start_cyc_o follows without busy_o ever dropping. With grant held and no request, ownership is kept idle.
- R8: With mode_busy=0 the block never starts a cycle, and from the second clock on it never drives the busy line.
- R9: While waiting for a busy bus, busy_oe stays 0. If req_i is 0 at a bus_ce clock during the wait, the block goes back to idle without driving the line.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Processor clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| bus_ce | input | 1 | Marks processor edges that are also bus-clock edges |
| mode_busy | input | 1 | Static: 1 selects the bus-busy ownership protocol |
| grant_i | input | 1 | Bus grant from the arbiter |
| start_i | input | 1 | Transfer-start line as seen on the bus |
| busy_i | input | 1 | Bus-busy line as seen on the bus |
| req_i | input | 1 | Sequencer wants to run bus cycles |
| done_i | input | 1 | Sequencer pulse: current bus cycle completed |
| start_cyc_o | output | 1 | One-clock pulse: a bus cycle may start now |
| busy_o | output | 1 | Value driven on the bus-busy line |
| busy_oe | output | 1 | Output enable for the bus-busy line |

## Verification
Two functions can fall on the same bus_ce edge: completion of a cycle through done_i, and either a relaunch (grant still held with a request) or a release (grant withdrawn). The bench raises done_i in exactly the clock that carries the deciding grant sample, once with grant held and once with grant dropped. It expects an immediate new start pulse with busy unbroken in the first case, and the one-clock negated drive in the second. A late or missed decision shows up as a wrong output triple in the clock after that edge.

// File: rtl/busy_owner_pkg.sv
package busy_owner_pkg;

  typedef enum logic [1:0] {
    ST_IDLE = 2'd0,
    ST_WAIT = 2'd1,
    ST_OWN  = 2'd2,
    ST_REL  = 2'd3
  } own_state_t;

  // Bus counts as free when granted and neither shared line is active.
  function automatic logic bus_is_free(input logic grant, input logic start, input logic busy);
    return grant & ~start & ~busy;
  endfunction

  // A started cycle is still open unless its completion arrives now.
  function automatic logic cycle_open(input logic active, input logic done);
    return active & ~done;
  endfunction

endpackage

// File: rtl/bown_sense.sv
module bown_sense
  import busy_owner_pkg::*;
(
  input  logic bus_ce,
  input  logic mode_on,
  input  logic grant_i,
  input  logic start_i,
  input  logic busy_i,
  output logic tick_o,
  output logic take_ok_o,
  output logic grant_hold_o,
  output logic grant_drop_o
);

  // Bus lines only matter on bus-clock edges and only in busy-line mode.
  assign tick_o       = bus_ce & mode_on;
  assign take_ok_o    = tick_o & bus_is_free(grant_i, start_i, busy_i);
  assign grant_hold_o = tick_o & grant_i;
  assign grant_drop_o = tick_o & ~grant_i;

endmodule

// File: rtl/bown_fsm.sv
module bown_fsm
  import busy_owner_pkg::*;
(
  input  logic       clk,
  input  logic       rst_n,
  input  logic       mode_on,
  input  logic       tick,
  input  logic       take_ok,
  input  logic       grant_hold,
  input  logic       grant_drop,
  input  logic       req_i,
  input  logic       done_i,
  output own_state_t st_q,
  output own_state_t st_d,
  output logic       launch_q,
  output logic       in_flight
);

  logic cyc_q, cyc_d, launch_d;

  assign in_flight = cycle_open(cyc_q, done_i);

  always_comb begin
    st_d     = st_q;
    launch_d = 1'b0;
    unique case (st_q)
      ST_IDLE: begin
        if (tick && req_i) begin
          if (take_ok) begin
            st_d     = ST_OWN;
            launch_d = 1'b1;
          end else begin
            st_d = ST_WAIT;
          end
        end
      end
      ST_WAIT: begin
        if (tick) begin
          if (!req_i) begin
            st_d = ST_IDLE;
          end else if (take_ok) begin
            st_d     = ST_OWN;
            launch_d = 1'b1;
          end
        end
      end
      ST_OWN: begin
        if (tick && !in_flight) begin
          if (grant_hold && req_i) launch_d = 1'b1;
          else if (grant_drop)     st_d     = ST_REL;
        end
      end
      ST_REL:  st_d = ST_IDLE;
      default: st_d = ST_IDLE;
    endcase
    if (!mode_on) begin
      st_d     = ST_IDLE;
      launch_d = 1'b0;
    end
  end

  always_comb begin
    if (!mode_on)     cyc_d = 1'b0;
    else if (launch_d) cyc_d = 1'b1;
    else if (done_i)   cyc_d = 1'b0;
    else               cyc_d = cyc_q;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      st_q     <= ST_IDLE;
      launch_q <= 1'b0;
      cyc_q    <= 1'b0;
    end else begin
      st_q     <= st_d;
      launch_q <= launch_d;
      cyc_q    <= cyc_d;
    end
  end

  assert_rel_one_clk_R5: assert property (@(posedge clk) disable iff (!rst_n)
    (st_q == ST_REL) |=> (st_q == ST_IDLE));

  assert_launch_only_owned_R3: assert property (@(posedge clk) disable iff (!rst_n)
    launch_q |-> (st_q == ST_OWN));

endmodule

// File: rtl/bown_drive.sv
module bown_drive
  import busy_owner_pkg::*;
(
  input  logic       clk,
  input  logic       rst_n,
  input  own_state_t st_d,
  output logic       busy_oe,
  output logic       busy_o
);

  // Registered straight from next state so the pad never sees decode glitches.
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      busy_oe <= 1'b0;
      busy_o  <= 1'b0;
    end else begin
      busy_oe <= (st_d == ST_OWN) || (st_d == ST_REL);
      busy_o  <= (st_d == ST_OWN);
    end
  end

endmodule

// File: rtl/busy_owner_ctl.sv
module busy_owner_ctl
  import busy_owner_pkg::*;
(
  input  logic clk,
  input  logic rst_n,
  input  logic bus_ce,
  input  logic mode_busy,
  input  logic grant_i,
  input  logic start_i,
  input  logic busy_i,
  input  logic req_i,
  input  logic done_i,
  output logic start_cyc_o,
  output logic busy_o,
  output logic busy_oe
);

  logic       tick_w, take_ok_w, grant_hold_w, grant_drop_w;
  logic       launch_w, in_flight_w, waiting_w;
  own_state_t st_q_w, st_d_w;

  bown_sense u_sense (
    .bus_ce      (bus_ce),
    .mode_on     (mode_busy),
    .grant_i     (grant_i),
    .start_i     (start_i),
    .busy_i      (busy_i),
    .tick_o      (tick_w),
    .take_ok_o   (take_ok_w),
    .grant_hold_o(grant_hold_w),
    .grant_drop_o(grant_drop_w)
  );

  bown_fsm u_fsm (
    .clk       (clk),
    .rst_n     (rst_n),
    .mode_on   (mode_busy),
    .tick      (tick_w),
    .take_ok   (take_ok_w),
    .grant_hold(grant_hold_w),
    .grant_drop(grant_drop_w),
    .req_i     (req_i),
    .done_i    (done_i),
    .st_q      (st_q_w),
    .st_d      (st_d_w),
    .launch_q  (launch_w),
    .in_flight (in_flight_w)
  );

  bown_drive u_drive (
    .clk    (clk),
    .rst_n  (rst_n),
    .st_d   (st_d_w),
    .busy_oe(busy_oe),
    .busy_o (busy_o)
  );

  assign start_cyc_o = launch_w;
  assign waiting_w   = (st_q_w == ST_WAIT);

  assert_take_needs_free_R2: assert property (@(posedge clk) disable iff (!rst_n)
    ($rose(busy_oe) && busy_o) |-> $past(bus_ce && mode_busy && grant_i && !start_i && !busy_i));

  assert_start_with_busy_R3: assert property (@(posedge clk) disable iff (!rst_n)
    start_cyc_o |-> (busy_oe && busy_o));

  assert_hold_until_done_R4: assert property (@(posedge clk) disable iff (!rst_n)
    ($fell(busy_o) && busy_oe) |-> $past(bus_ce && !grant_i && !in_flight_w));

  assert_negate_one_clk_R5: assert property (@(posedge clk) disable iff (!rst_n)
    (busy_oe && !busy_o) |=> !busy_oe);

  assert_relaunch_granted_R7: assert property (@(posedge clk) disable iff (!rst_n)
    start_cyc_o |-> $past(grant_i && bus_ce));

  assert_mode_off_quiet_R8: assert property (@(posedge clk) disable iff (!rst_n)
    (!mode_busy && $past(!mode_busy)) |-> (!busy_oe && !start_cyc_o));

  assert_wait_no_drive_R9: assert property (@(posedge clk) disable iff (!rst_n)
    waiting_w |-> !busy_oe);

endmodule

// File: tb/busy_owner_ctl_test.sv
module busy_owner_ctl_test;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic bus_ce = 1'b0, mode_busy = 1'b1, grant_i = 1'b0, start_i = 1'b0;
  logic busy_i = 1'b0, req_i = 1'b0, done_i = 1'b0;
  logic start_cyc_o, busy_o, busy_oe;

  int total = 0;
  int bad = 0;
  int cyc = 0;
  bit finished = 1'b0;

  typedef struct {
    int    due;
    logic  oe;
    logic  val;
    logic  st;
    string tag;
  } exp_t;
  exp_t sb[$];

  always #10 clk = ~clk;

  busy_owner_ctl uut (
    .clk(clk), .rst_n(rst_n), .bus_ce(bus_ce), .mode_busy(mode_busy),
    .grant_i(grant_i), .start_i(start_i), .busy_i(busy_i), .req_i(req_i),
    .done_i(done_i), .start_cyc_o(start_cyc_o), .busy_o(busy_o), .busy_oe(busy_oe)
  );

  always @(posedge clk) cyc <= cyc + 1;

  // Monitor: pops every expectation due in this cycle, away from the edge.
  always @(negedge clk) begin
    while (sb.size() > 0 && sb[0].due == cyc) begin
      exp_t e;
      e = sb.pop_front();
      total++;
      if (busy_oe !== e.oe || busy_o !== e.val || start_cyc_o !== e.st) begin
        bad++;
        $display("FAIL %s cycle %0d oe/val/start actual %b%b%b expected %b%b%b",
                 e.tag, cyc, busy_oe, busy_o, start_cyc_o, e.oe, e.val, e.st);
      end
    end
  end

  // Driver: applies one clock of stimulus and queues the outputs expected after it.
  task automatic step(input logic m, input logic ce, input logic g, input logic s,
                      input logic b, input logic rq, input logic dn,
                      input logic eo, input logic ev, input logic es, input string tag);
    exp_t e;
    @(posedge clk);
    #2;
    mode_busy = m; bus_ce = ce; grant_i = g; start_i = s;
    busy_i = b; req_i = rq; done_i = dn;
    e.due = cyc + 1; e.oe = eo; e.val = ev; e.st = es; e.tag = tag;
    sb.push_back(e);
  endtask

  task automatic finish_run();
    if (!finished) begin
      finished = 1'b1;
      $display("  test done: total=%0d bad=%0d", total, bad);
      $finish;
    end
  endtask

  initial begin
    #(20 * 5000);
    total++;
    bad++;
    $display("FAIL watchdog expired, queue depth actual %0d expected 0", sb.size());
    finish_run();
  end

  initial begin
    repeat (3) @(negedge clk);
    total++;
    if (busy_oe !== 1'b0 || busy_o !== 1'b0 || start_cyc_o !== 1'b0) begin
      bad++;
      $display("FAIL R1 in reset actual %b%b%b expected 000", busy_oe, busy_o, start_cyc_o);
    end
    rst_n = 1'b1;
    //    m  ce g  s  b  rq dn   oe v  st
    step(1, 0, 0, 0, 0, 0, 0,  0, 0, 0, "R1");
    step(1, 1, 0, 0, 0, 1, 0,  0, 0, 0, "R9");  // no grant -> wait
    step(1, 0, 1, 0, 0, 1, 0,  0, 0, 0, "R2");  // free but no ce edge
    step(1, 1, 1, 0, 1, 1, 0,  0, 0, 0, "R9");  // other master busy
    step(1, 1, 1, 1, 0, 1, 0,  0, 0, 0, "R2");  // start line active
    step(1, 1, 1, 0, 0, 1, 0,  1, 1, 1, "R3");  // take bus
    step(1, 0, 1, 0, 0, 1, 0,  1, 1, 0, "R3");  // single pulse
    step(1, 1, 0, 0, 0, 0, 0,  1, 1, 0, "R4");  // grant gone, cycle open
    step(1, 0, 0, 0, 0, 0, 1,  1, 1, 0, "R4");  // done off ce edge
    step(1, 0, 0, 0, 0, 0, 0,  1, 1, 0, "R4");
    step(1, 1, 0, 0, 0, 0, 0,  1, 0, 0, "R5");  // release drive
    step(1, 0, 0, 0, 0, 0, 0,  0, 0, 0, "R5");  // tri-state without ce
    step(1, 1, 1, 0, 1, 1, 0,  0, 0, 0, "R6");  // line watched again
    step(1, 1, 1, 0, 0, 1, 0,  1, 1, 1, "R6");
    step(1, 1, 1, 0, 0, 1, 1,  1, 1, 1, "R7");  // done + relaunch same edge
    step(1, 1, 1, 0, 0, 1, 0,  1, 1, 0, "R7");
    step(1, 1, 1, 0, 0, 0, 1,  1, 1, 0, "R7");  // parked with grant
    step(1, 1, 0, 0, 0, 0, 0,  1, 0, 0, "R5");
    step(1, 1, 0, 0, 0, 0, 0,  0, 0, 0, "R5");
    step(1, 1, 0, 0, 0, 1, 0,  0, 0, 0, "R9");
    step(1, 1, 1, 0, 0, 0, 0,  0, 0, 0, "R9");  // request withdrawn
    step(1, 1, 1, 0, 0, 0, 0,  0, 0, 0, "R9");
    step(0, 1, 1, 0, 0, 1, 0,  0, 0, 0, "R8");
    step(0, 1, 1, 0, 0, 1, 0,  0, 0, 0, "R8");
    step(1, 1, 1, 0, 0, 1, 0,  1, 1, 1, "R2");
    step(1, 1, 0, 0, 0, 0, 1,  1, 0, 0, "R4");  // done + grant drop same edge
    step(1, 0, 0, 0, 0, 0, 0,  0, 0, 0, "R5");
    repeat (3) @(posedge clk);
    @(negedge clk);
    finish_run();
  end

endmodule